// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer and Field Decoder

This block sits at the front of a small accumulator-based controller core that runs 14-bit instruction words. It divides the input clock into instruction cycles of four phases each and reports the current phase. In the last phase it raises a fetch strobe and latches the program-memory word into an instruction register. The held word is split into the operand fields of its format: file-register operations, single-bit operations, immediate-literal operations and long call/jump operations.

When the executing instruction takes a conditional skip or writes the program counter, the sequencer does not load the word fetched in that cycle. It loads the all-zero word instead, which decodes as a no-operation. The pipeline therefore spends one extra instruction cycle while the new target is fetched. Fields that do not belong to the current format are driven to zero, so that downstream logic can use them without further qualification.

Top module: `iseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the phase resets to index 0 and the instruction register resets to 14'h0000, so the format reads 2'b00 and every field reads zero.
- R2: `phase` advances by one on each clock, 0→1→2→3→0. Indices 0 to 3 stand for phases one to four.
- R3: `fetch_strobe` is high exactly when `phase` is 3.
- R4: At the clock edge that ends phase index 3, `instr` takes `pm_data` if neither flag is high. It keeps its value at all other edges.
- R5: If `skip_taken` or `pc_write` (or both) is high at the edge that ends phase index 3, `instr` becomes 14'h0000 for exactly the next instruction cycle.
- R6: `skip_taken` and `pc_write` have no effect at edges that end phase indices 0, 1 or 2.
- R7: `fmt` equals `instr[13:12]`: 00 file-register, 01 bit, 10 call/jump, 11 literal.
- R8: `opcode` is `instr[13:8]` for the file-register and literal formats, `{2'b00,instr[13:10]}` for the bit format, and `{3'b000,instr[13:11]}` for call/jump. `dest_file` is `instr[7]` in the file-register format and 0 otherwise. `file_addr` is `instr[6:0]` in the file-register and bit formats and 0 otherwise.
- R9: `bit_num` is `instr[9:7]` in the bit format and 0 otherwise.
- R10: `imm` is `instr[7:0]` in the literal format and 0 otherwise. `jump_addr` is `instr[10:0]` in the call/jump format and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one phase |
| rst | input | 1 | Synchronous active-high reset |
| pm_data | input | 14 | Word read from program memory |
| skip_taken | input | 1 | Executing instruction's skip condition is true |
| pc_write | input | 1 | Executing instruction writes the program counter |
| phase | output | 2 | Phase index 0..3 within the instruction cycle |
| fetch_strobe | output | 1 | High in the phase whose closing edge latches pm_data |
| instr | output | 14 | Held instruction word |
| fmt | output | 2 | Format code |
| opcode | output | 6 | Opcode, right-aligned for the format |
| dest_file | output | 1 | 1 = result to file register, 0 = to W |
| file_addr | output | 7 | File register address |
| bit_num | output | 3 | Bit number |
| imm | output | 8 | 8-bit immediate |
| jump_addr | output | 11 | 11-bit call/jump target |

## Verification
A normal fetch-and-latch and a flush can both fall on the same closing edge of phase index 3. The flush must win, and it must last for one instruction cycle only. The bench sets `skip_taken` and `pc_write` high, alone and together, in that phase, with random words on `pm_data`. It expects zero in `instr` for one instruction cycle, followed by the next word fetched. The same flags are also raised in the other three phases, where the held word must stay unchanged.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
    localparam int IW    = 14;
    localparam int OPW   = 6;
    localparam int FA_W  = 7;
    localparam int BN_W  = 3;
    localparam int IMM_W = 8;
    localparam int JA_W  = 11;

    typedef logic [IW-1:0] iword_t;

    typedef enum logic [1:0] {
        FMT_BYTE = 2'b00,
        FMT_BIT  = 2'b01,
        FMT_JUMP = 2'b10,
        FMT_LIT  = 2'b11
    } fmt_t;

    typedef struct packed {
        fmt_t              fmt;
        logic [OPW-1:0]    opcode;
        logic              dest;
        logic [FA_W-1:0]   faddr;
        logic [BN_W-1:0]   bnum;
        logic [IMM_W-1:0]  imm;
        logic [JA_W-1:0]   jaddr;
    } fields_t;

    // Split a held word into its format-qualified fields.
    function automatic fields_t split_word(input iword_t w);
        fields_t f;
        f       = '0;
        f.fmt   = fmt_t'(w[13:12]);
        unique case (f.fmt)
            FMT_BYTE: begin
                f.opcode = w[13:8];
                f.dest   = w[7];
                f.faddr  = w[6:0];
            end
            FMT_BIT: begin
                f.opcode = {2'b00, w[13:10]};
                f.bnum   = w[9:7];
                f.faddr  = w[6:0];
            end
            FMT_JUMP: begin
                f.opcode = {3'b000, w[13:11]};
                f.jaddr  = w[10:0];
            end
            FMT_LIT: begin
                f.opcode = w[13:8];
                f.imm    = w[7:0];
            end
            default: f = '0;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/iseq_phase_gen.sv
module iseq_phase_gen #(
    parameter int NPH = 4,
    localparam int PHW = $clog2(NPH)
) (
    input  logic           clk,
    input  logic           rst,
    output logic [PHW-1:0] ph,
    output logic           last
);
    localparam logic [PHW-1:0] PH_LAST = PHW'(NPH - 1);

    assign last = (ph == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst)       ph <= '0;
        else if (last) ph <= '0;
        else           ph <= ph + 1'b1;
    end

    // R2
    ph_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_LAST) |=> (ph == '0));
    // R2
    ph_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_LAST) |=> (ph == $past(ph) + 1'b1));
endmodule

// File: rtl/iseq_ir.sv
module iseq_ir
    import iseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_en,
    input  logic   flush,
    input  iword_t pm_data,
    output iword_t ir
);
    always_ff @(posedge clk) begin
        if (rst)          ir <= '0;
        else if (load_en) ir <= flush ? '0 : pm_data;
    end

    // R4 R6
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(ir));
    // R4
    ir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && !flush) |=> (ir == $past(pm_data)));
    // R5
    ir_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && flush) |=> (ir == '0));
endmodule

// File: rtl/iseq_decode.sv
module iseq_decode
    import iseq_pkg::*;
(
    input  iword_t  ir,
    output fields_t fld
);
    always_comb fld = split_word(ir);
endmodule

// File: rtl/iseq_top.sv
module iseq_top
    import iseq_pkg::*;
#(
    parameter int NPH = 4,
    localparam int PHW = $clog2(NPH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IW-1:0]     pm_data,
    input  logic              skip_taken,
    input  logic              pc_write,
    output logic [PHW-1:0]    phase,
    output logic              fetch_strobe,
    output logic [IW-1:0]     instr,
    output logic [1:0]        fmt,
    output logic [OPW-1:0]    opcode,
    output logic              dest_file,
    output logic [FA_W-1:0]   file_addr,
    output logic [BN_W-1:0]   bit_num,
    output logic [IMM_W-1:0]  imm,
    output logic [JA_W-1:0]   jump_addr
);
    logic    last_ph;
    iword_t  ir_q;
    fields_t fld;

    iseq_phase_gen #(.NPH(NPH)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .ph   (phase),
        .last (last_ph)
    );

    iseq_ir u_ir (
        .clk     (clk),
        .rst     (rst),
        .load_en (last_ph),
        .flush   (skip_taken | pc_write),
        .pm_data (pm_data),
        .ir      (ir_q)
    );

    iseq_decode u_dec (
        .ir  (ir_q),
        .fld (fld)
    );

    assign fetch_strobe = last_ph;
    assign instr        = ir_q;
    assign fmt          = fld.fmt;
    assign opcode       = fld.opcode;
    assign dest_file    = fld.dest;
    assign file_addr    = fld.faddr;
    assign bit_num      = fld.bnum;
    assign imm          = fld.imm;
    assign jump_addr    = fld.jaddr;

    // R9
    bitnum_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[13:12] != 2'b01) |-> (bit_num == '0));
    // R10
    imm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (instr[13:12] != 2'b11) |-> (imm == '0));
    // R3
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_strobe |=> !fetch_strobe);
endmodule

// File: tb/tb_iseq_top.sv
`timescale 1ns/1ps
module tb_iseq_top;
    logic        clk = 0;
    logic        rst;
    logic [13:0] pm_data;
    logic        skip_taken, pc_write;
    logic [1:0]  phase;
    logic        fetch_strobe;
    logic [13:0] instr;
    logic [1:0]  fmt;
    logic [5:0]  opcode;
    logic        dest_file;
    logic [6:0]  file_addr;
    logic [2:0]  bit_num;
    logic [7:0]  imm;
    logic [10:0] jump_addr;

    int n_chk = 0;
    int n_bad = 0;

    int          exp_ph;
    logic [13:0] exp_ir;
    string       cause;

    always #10 clk = ~clk;

    iseq_top dut (
        .clk(clk), .rst(rst), .pm_data(pm_data), .skip_taken(skip_taken),
        .pc_write(pc_write), .phase(phase), .fetch_strobe(fetch_strobe),
        .instr(instr), .fmt(fmt), .opcode(opcode), .dest_file(dest_file),
        .file_addr(file_addr), .bit_num(bit_num), .imm(imm), .jump_addr(jump_addr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] e_opcode(input logic [13:0] w);
        if (w[13:12] == 2'b01) return {2'b00, w[13:10]};
        if (w[13:12] == 2'b10) return {3'b000, w[13:11]};
        return w[13:8];
    endfunction
    function automatic logic e_dest(input logic [13:0] w);
        return (w[13:12] == 2'b00) ? w[7] : 1'b0;
    endfunction
    function automatic logic [6:0] e_faddr(input logic [13:0] w);
        return (w[13] == 1'b0) ? w[6:0] : 7'd0;
    endfunction
    function automatic logic [2:0] e_bnum(input logic [13:0] w);
        return (w[13:12] == 2'b01) ? w[9:7] : 3'd0;
    endfunction
    function automatic logic [7:0] e_imm(input logic [13:0] w);
        return (w[13:12] == 2'b11) ? w[7:0] : 8'd0;
    endfunction
    function automatic logic [10:0] e_jaddr(input logic [13:0] w);
        return (w[13:12] == 2'b10) ? w[10:0] : 11'd0;
    endfunction

    task automatic check_all();
        check(phase == 2'(exp_ph), "R2 phase", phase, exp_ph);
        check(fetch_strobe == (exp_ph == 3), "R3 strobe", fetch_strobe, exp_ph == 3);
        check(instr == exp_ir, {cause, " instr"}, instr, exp_ir);
        check(fmt == exp_ir[13:12], "R7 fmt", fmt, exp_ir[13:12]);
        check(opcode == e_opcode(exp_ir), "R8 opcode", opcode, e_opcode(exp_ir));
        check(dest_file == e_dest(exp_ir), "R8 dest", dest_file, e_dest(exp_ir));
        check(file_addr == e_faddr(exp_ir), "R8 file_addr", file_addr, e_faddr(exp_ir));
        check(bit_num == e_bnum(exp_ir), "R9 bit_num", bit_num, e_bnum(exp_ir));
        check(imm == e_imm(exp_ir), "R10 imm", imm, e_imm(exp_ir));
        check(jump_addr == e_jaddr(exp_ir), "R10 jump_addr", jump_addr, e_jaddr(exp_ir));
    endtask

    // Advance one clock with the given inputs and update the expectation.
    task automatic step(input logic [13:0] w, input logic s, input logic p);
        pm_data = w; skip_taken = s; pc_write = p;
        @(posedge clk); #1;
        if (exp_ph == 3) begin
            if (s || p) begin exp_ir = 14'h0; cause = "R5"; end
            else        begin exp_ir = w;     cause = "R4"; end
        end else if (s || p) begin
            cause = "R6";
        end
        exp_ph = (exp_ph + 1) % 4;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1; pm_data = 14'h3FFF; skip_taken = 0; pc_write = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        exp_ph = 0; exp_ir = 14'h0; cause = "R1";
        // R1 reset state
        check(phase == 2'd0, "R1 phase", phase, 0);
        check(instr == 14'h0, "R1 instr", instr, 0);
        check(fmt == 2'b00 && imm == 0 && jump_addr == 0, "R1 fields", fmt, 0);

        // Directed: one word per format, flags off-phase (R6), both flags in phase 4 (R5)
        for (int i = 0; i < 4; i++) step(14'h0A85, i == 1, i == 2);  // byte fmt, R6
        for (int i = 0; i < 4; i++) step(14'h1F2B, 1'b0, 1'b0);      // bit fmt
        for (int i = 0; i < 4; i++) step(14'h2ABC, i == 3, i == 3);  // simultaneous flush
        for (int i = 0; i < 4; i++) step(14'h3C5A, 1'b0, 1'b0);      // literal after flush
        for (int i = 0; i < 4; i++) step(14'h2F01, 1'b0, i == 3);    // pc write only
        for (int i = 0; i < 4; i++) step(14'h17FF, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(14'h3FFF, i == 3, 1'b0);    // skip only
        for (int i = 0; i < 4; i++) step(14'h2000, 1'b0, 1'b0);

        // Constrained random
        for (int i = 0; i < 1200; i++)
            step(14'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule